// File: doc/BRIEF.md
# Sector Read Deframer with Rotating Check Byte

This block sits behind the bit-level read channel of a floppy-style disk controller and handles one sector at a time. The channel hands it a stream of decoded bytes, each marked by a one-cycle valid strobe. Once a start strobe arms it, the block hunts for a run of zero bytes, locks onto the sync pattern and raises a body flag. It then forwards each payload byte on a registered output with its own valid strobe, and folds every payload byte into a running check character.

The frame layout follows a density select that is captured at the start strobe. Single density uses one sync byte of 0xFB followed by 256 payload bytes. Double density uses two consecutive 0xFB bytes followed by 512 payload bytes. In both cases one check byte follows the payload. The zero run that comes before the sync may be one byte shorter than its nominal 16 (single) or 32 (double) bytes.

When the check byte arrives, the block issues a one-cycle done pulse. It raises either a match flag or a mismatch flag, and that flag holds until the next start strobe. A sector-hole input abandons a frame that is in progress.

Top module: `sector_deframer`

## Requirements
- R1: After reset, body_o, dat_vld_o, done_o, ok_o and err_o are all low.
- R2: With density 0 captured at start, a byte 0xFB that follows at least 15 consecutive 0x00 bytes is taken as the sync. The next 256 bytes then appear on dat_o in arrival order, each with dat_vld_o high in the cycle after its input strobe.
- R3: With density 1 captured at start, two consecutive 0xFB bytes that follow at least 31 consecutive 0x00 bytes form the sync. The next 512 bytes are delivered as in R2. The density input is sampled only on the start strobe.
- R4: body_o rises in the cycle after the final sync byte is accepted. It stays high through the payload and the check byte, and it is low in the cycle after the check byte is accepted.
- R5: The check value starts at 0x00. Each payload byte d replaces it with rotate_left_1(value XOR d), where bit 7 of the XOR result moves into bit 0. The byte after the last payload byte is compared with this value. done_o pulses high for exactly one cycle, in the cycle after the check byte is accepted, and ok_o goes high on a match.
- R6: A 0xFB that follows fewer than 15 (density 0) or 31 (density 1) zero bytes is not a sync. It clears the zero count, and body_o stays low.
- R7: On a check-byte mismatch, err_o goes high and ok_o stays low. ok_o and err_o are never high together.
- R8: While hunting, any non-zero byte that is not an accepted sync clears the zero count. In density 1, a second byte other than 0xFB after the first sync returns the block to hunting with a zero count of 0.
- R9: A hole_i pulse while hunting or inside a frame abandons the frame. body_o is low in the next cycle, and later bytes produce neither dat_vld_o nor done_o until the next start.
- R10: Before the first start strobe, and after a completed frame, incoming bytes change none of the outputs.
- R11: start_i clears ok_o and err_o in the next cycle and re-arms the hunt with a zero count of 0. start_i takes priority over hole_i and over an incoming byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms the hunt for a new sector; captures density |
| hole_i | input | 1 | Sector hole strobe; abandons a frame in progress |
| dbl_i | input | 1 | Density select: 0 single, 1 double |
| byte_vld_i | input | 1 | Strobe marking a valid input byte |
| byte_i | input | DATA_W | Decoded byte from the read channel |
| body_o | output | 1 | High from sync lock until the check byte is consumed |
| dat_vld_o | output | 1 | Strobe for each forwarded payload byte |
| dat_o | output | DATA_W | Forwarded payload byte |
| done_o | output | 1 | One-cycle pulse after the check byte |
| ok_o | output | 1 | Check byte matched; held until next start |
| err_o | output | 1 | Check byte mismatched; held until next start |

## Verification
The properties assume that start_i and hole_i are short strobes, and that the read channel delivers at most one byte per cycle. They also assume the design is observed only once reset has been released. The stimulus drives every input on the falling clock edge, gives each byte one cycle, and issues start and hole as single-cycle pulses between bytes. A scoreboard queue holds the payload bytes expected from each accepted frame, so any forwarded byte from a rejected or abandoned frame shows up as a miscompare. The frames cover both densities, nominal and shortened zero runs, one-byte-short runs, broken sync pairs, corrupted check bytes and a sector hole in the middle of the payload.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HUNT  = 3'd1,
      ST_SYNC2 = 3'd2,
      ST_BODY  = 3'd3,
      ST_CHECK = 3'd4,
      ST_DONE  = 3'd5
   } sdf_state_e;
endpackage

// File: rtl/sdf_preamble.sv
// Zero-run counter and sync recogniser for the hunting phase.
module sdf_preamble #(
   parameter int DATA_W    = 8,
   parameter int SD_PRE    = 16,
   parameter int DD_PRE    = 32,
   parameter int PRE_SLACK = 1,
   parameter logic [DATA_W-1:0] SYNC_VAL = 8'hFB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              upd_i,
   input  logic              dbl_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              is_sync_o,
   output logic              pre_ok_o
);
   localparam int MAX_PRE = (DD_PRE > SD_PRE) ? DD_PRE : SD_PRE;
   localparam int ZW      = $clog2(MAX_PRE + 1);
   localparam logic [ZW-1:0] Z_SAT = ZW'(MAX_PRE);

   logic [ZW-1:0] zcnt_q;
   logic [ZW-1:0] sd_min, dd_min;
   logic          is_zero;

   assign is_zero   = (din_i == '0);
   assign is_sync_o = (din_i == SYNC_VAL);

   generate
      if (PRE_SLACK == 0) begin : g_exact
         assign sd_min = ZW'(SD_PRE);
         assign dd_min = ZW'(DD_PRE);
      end else begin : g_slack
         assign sd_min = ZW'(SD_PRE - PRE_SLACK);
         assign dd_min = ZW'(DD_PRE - PRE_SLACK);
      end
   endgenerate

   assign pre_ok_o = dbl_i ? (zcnt_q >= dd_min) : (zcnt_q >= sd_min);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zcnt_q <= '0;
      end else if (clr_i) begin
         zcnt_q <= '0;
      end else if (upd_i) begin
         if (!is_zero)
            zcnt_q <= '0;
         else if (zcnt_q != Z_SAT)
            zcnt_q <= zcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdf_check_accum.sv
// Running check character: XOR with the byte, then rotate left by one.
module sdf_check_accum #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              upd_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] acc_o
);
   logic [DATA_W-1:0] mix;

   assign mix = acc_o ^ din_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_o <= '0;
      else if (clr_i)
         acc_o <= '0;
      else if (upd_i)
         acc_o <= {mix[DATA_W-2:0], mix[DATA_W-1]};
   end
endmodule

// File: rtl/sdf_frame_ctl.sv
// Frame sequencer: hunt, sync, payload count, check, done.
module sdf_frame_ctl
   import sdf_pkg::*;
#(
   parameter int SD_LEN = 256,
   parameter int DD_LEN = 512
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hole_i,
   input  logic       dbl_i,
   input  logic       vld_i,
   input  logic       is_sync_i,
   input  logic       pre_ok_i,
   output sdf_state_e state_o,
   output logic       dbl_o,
   output logic       hunt_step_o,
   output logic       take_data_o,
   output logic       take_check_o
);
   localparam int MAX_LEN = (DD_LEN > SD_LEN) ? DD_LEN : SD_LEN;
   localparam int CW      = $clog2(MAX_LEN);
   localparam logic [CW-1:0] SD_LAST = CW'(SD_LEN - 1);
   localparam logic [CW-1:0] DD_LAST = CW'(DD_LEN - 1);

   sdf_state_e    state_q, state_d;
   logic [CW-1:0] dcnt_q;
   logic          dbl_q;
   logic          step, in_frame, last_data;

   assign step      = vld_i && !start_i && !hole_i;
   assign in_frame  = (state_q == ST_HUNT) || (state_q == ST_SYNC2) ||
                      (state_q == ST_BODY) || (state_q == ST_CHECK);
   assign last_data = (dcnt_q == (dbl_q ? DD_LAST : SD_LAST));

   assign hunt_step_o  = step && (state_q == ST_HUNT);
   assign take_data_o  = step && (state_q == ST_BODY);
   assign take_check_o = step && (state_q == ST_CHECK);
   assign state_o      = state_q;
   assign dbl_o        = dbl_q;

   always_comb begin
      state_d = state_q;
      if (start_i) begin
         state_d = ST_HUNT;
      end else if (hole_i && in_frame) begin
         state_d = ST_IDLE;
      end else if (vld_i) begin
         case (state_q)
            ST_HUNT:  if (is_sync_i && pre_ok_i)
                         state_d = dbl_q ? ST_SYNC2 : ST_BODY;
            ST_SYNC2: state_d = is_sync_i ? ST_BODY : ST_HUNT;
            ST_BODY:  if (last_data) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_DONE;
            default:  state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dbl_q   <= 1'b0;
         dcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         if (start_i)
            dbl_q <= dbl_i;
         if (state_q != ST_BODY)
            dcnt_q <= '0;
         else if (take_data_o)
            dcnt_q <= dcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sector_deframer.sv
module sector_deframer
   import sdf_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SD_LEN    = 256,
   parameter int DD_LEN    = 512,
   parameter int SD_PRE    = 16,
   parameter int DD_PRE    = 32,
   parameter int PRE_SLACK = 1,
   parameter logic [DATA_W-1:0] SYNC_VAL = 8'hFB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              hole_i,
   input  logic              dbl_i,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic              body_o,
   output logic              dat_vld_o,
   output logic [DATA_W-1:0] dat_o,
   output logic              done_o,
   output logic              ok_o,
   output logic              err_o
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("sector_deframer: DATA_W must be at least 2");
      end
      if (SD_LEN < 2 || DD_LEN < 2) begin : g_bad_len
         $error("sector_deframer: payload lengths must be at least 2");
      end
      if (PRE_SLACK < 0 || PRE_SLACK >= SD_PRE || PRE_SLACK >= DD_PRE) begin : g_bad_pre
         $error("sector_deframer: PRE_SLACK must be below both preamble lengths");
      end
   endgenerate

   sdf_state_e        state;
   logic              dbl_q, hunt_step, take_data, take_check;
   logic              is_sync, pre_ok;
   logic [DATA_W-1:0] acc;

   sdf_frame_ctl #(
      .SD_LEN (SD_LEN),
      .DD_LEN (DD_LEN)
   ) u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .hole_i       (hole_i),
      .dbl_i        (dbl_i),
      .vld_i        (byte_vld_i),
      .is_sync_i    (is_sync),
      .pre_ok_i     (pre_ok),
      .state_o      (state),
      .dbl_o        (dbl_q),
      .hunt_step_o  (hunt_step),
      .take_data_o  (take_data),
      .take_check_o (take_check)
   );

   sdf_preamble #(
      .DATA_W    (DATA_W),
      .SD_PRE    (SD_PRE),
      .DD_PRE    (DD_PRE),
      .PRE_SLACK (PRE_SLACK),
      .SYNC_VAL  (SYNC_VAL)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (start_i),
      .upd_i     (hunt_step),
      .dbl_i     (dbl_q),
      .din_i     (byte_i),
      .is_sync_o (is_sync),
      .pre_ok_o  (pre_ok)
   );

   sdf_check_accum #(
      .DATA_W (DATA_W)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_i),
      .upd_i (take_data),
      .din_i (byte_i),
      .acc_o (acc)
   );

   assign body_o = (state == ST_BODY) || (state == ST_CHECK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_vld_o <= 1'b0;
         dat_o     <= '0;
         done_o    <= 1'b0;
         ok_o      <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         dat_vld_o <= take_data;
         done_o    <= take_check;
         if (take_data)
            dat_o <= byte_i;
         if (start_i) begin
            ok_o  <= 1'b0;
            err_o <= 1'b0;
         end else if (take_check) begin
            ok_o  <= (byte_i == acc);
            err_o <= (byte_i != acc);
         end
      end
   end
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
   parameter int DD_LEN = 512
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic hole_i,
   input logic body_o,
   input logic dat_vld_o,
   input logic done_o,
   input logic ok_o,
   input logic err_o
);
   localparam int KW = $clog2(DD_LEN + 2);
   logic [KW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (!body_o)
         seen_q <= '0;
      else if (dat_vld_o && seen_q <= KW'(DD_LEN))
         seen_q <= seen_q + 1'b1;
   end

   a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q <= KW'(DD_LEN));

   a_r4_data_in_body: assert property (@(posedge clk) disable iff (!rst_n)
      dat_vld_o |-> body_o);

   a_r4_body_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(body_o) |-> (done_o || $past(hole_i) || $past(start_i)));

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r5_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ok_o ^ err_o));

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && err_o));

   a_r9_hole_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (hole_i && !start_i) |=> (!body_o && !done_o && !dat_vld_o));

   a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!ok_o && !err_o && !body_o));
endmodule

bind sector_deframer sdf_checker #(.DD_LEN(DD_LEN)) u_sdf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .hole_i    (hole_i),
   .body_o    (body_o),
   .dat_vld_o (dat_vld_o),
   .done_o    (done_o),
   .ok_o      (ok_o),
   .err_o     (err_o)
);

// File: tb/sector_deframer_test.sv
`timescale 1ns/1ps
module sector_deframer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       hole_i = 1'b0;
   logic       dbl_i = 1'b0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       body_o, dat_vld_o, done_o, ok_o, err_o;
   logic [7:0] dat_o;

   int checks = 0;
   int fails  = 0;
   int got    = 0;
   bit ended  = 1'b0;
   logic [7:0] expq[$];

   always #10 clk = ~clk;

   sector_deframer uut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .hole_i (hole_i),
      .dbl_i (dbl_i), .byte_vld_i (byte_vld_i), .byte_i (byte_i),
      .body_o (body_o), .dat_vld_o (dat_vld_o), .dat_o (dat_o),
      .done_o (done_o), .ok_o (ok_o), .err_o (err_o)
   );

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && dat_vld_o) begin
         got++;
         if (expq.size() == 0) begin
            chk(1'b0, "R10 unexpected payload byte", dat_o, 0);
         end else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(dat_o == e, "R2 payload order", dat_o, e);
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_vld_i = 1'b1;
      byte_i     = b;
   endtask

   task automatic quiet();
      @(negedge clk);
      byte_vld_i = 1'b0;
      byte_i     = 8'h00;
   endtask

   task automatic pulse_start(input bit dd);
      @(negedge clk);
      byte_vld_i = 1'b0;
      dbl_i      = dd;
      start_i    = 1'b1;
      @(negedge clk);
      start_i    = 1'b0;
      dbl_i      = ~dd;   // density must be held from the start strobe only (R3)
      chk(!ok_o && !err_o, "R11 start clears flags", {ok_o, err_o}, 0);
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed * 37) + (i * 13) + (i >> 3));
   endfunction

   // full frame; expect_take says whether the payload should be forwarded
   task automatic frame(input bit dd, input int npre, input int seed,
                        input bit bad, input bit expect_take);
      int len;
      logic [7:0] acc, d, x;
      len = dd ? 512 : 256;
      acc = 8'h00;
      got = 0;
      for (int i = 0; i < npre; i++) send(8'h00);
      if (dd) send(8'hFB);
      send(8'hFB);
      chk(body_o == 1'b0, "R4 body low before last sync taken", body_o, 0);
      for (int i = 0; i < len; i++) begin
         d = pat(seed, i);
         send(d);
         if (i == 0)
            chk(body_o == expect_take, "R4 body after sync", body_o, expect_take);
         if (expect_take) expq.push_back(d);
         x   = acc ^ d;
         acc = {x[6:0], x[7]};
      end
      send(bad ? (acc ^ 8'h10) : acc);
      quiet();
      if (expect_take) begin
         chk(done_o == 1'b1, "R5 done pulse after check byte", done_o, 1);
         chk(ok_o == !bad, bad ? "R7 ok low on mismatch" : "R5 ok on match", ok_o, !bad);
         chk(err_o == bad, "R7 err flag", err_o, bad);
         chk(body_o == 1'b0, "R4 body low after check", body_o, 0);
         @(negedge clk);
         chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
         chk(ok_o == !bad, "R5 flag held", ok_o, !bad);
         chk(got == len, dd ? "R3 payload count" : "R2 payload count", got, len);
      end else begin
         chk(done_o == 1'b0, "R10 no done", done_o, 0);
         chk(got == 0, "R10 no payload", got, 0);
      end
      chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!ended) begin
         ended = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({body_o, dat_vld_o, done_o, ok_o, err_o} == 5'b0, "R1 reset outputs",
          {body_o, dat_vld_o, done_o, ok_o, err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: no start yet, full frame ignored
      frame(1'b0, 16, 1, 1'b0, 1'b0);
      chk(ok_o == 0 && err_o == 0, "R10 flags idle", {ok_o, err_o}, 0);

      // R2: nominal single density
      pulse_start(1'b0);
      frame(1'b0, 16, 2, 1'b0, 1'b1);

      // R10: after done further bytes change nothing
      frame(1'b0, 16, 3, 1'b1, 1'b0);
      chk(ok_o == 1 && err_o == 0, "R10 flags kept after done", {ok_o, err_o}, 2);

      // R3: nominal double density (dbl_i toggled after start)
      pulse_start(1'b1);
      frame(1'b1, 32, 4, 1'b0, 1'b1);

      // R6: shortened runs accepted
      pulse_start(1'b0);
      frame(1'b0, 15, 5, 1'b0, 1'b1);
      pulse_start(1'b1);
      frame(1'b1, 31, 6, 1'b0, 1'b1);

      // R6: one zero too few in single density
      pulse_start(1'b0);
      for (int i = 0; i < 14; i++) send(8'h00);
      send(8'hFB);
      send(8'h00);
      chk(body_o == 1'b0, "R6 short run rejected", body_o, 0);
      quiet();
      frame(1'b0, 16, 7, 1'b0, 1'b1);

      // R6: one zero too few in double density
      pulse_start(1'b1);
      for (int i = 0; i < 30; i++) send(8'h00);
      send(8'hFB);
      send(8'hFB);
      send(8'h00);
      chk(body_o == 1'b0, "R6 short double run rejected", body_o, 0);
      quiet();
      frame(1'b1, 32, 8, 1'b0, 1'b1);

      // R8: stray byte clears zero count
      pulse_start(1'b0);
      for (int i = 0; i < 16; i++) send(8'h00);
      send(8'h55);
      for (int i = 0; i < 5; i++) send(8'h00);
      send(8'hFB);
      send(8'h00);
      chk(body_o == 1'b0, "R8 stray byte restarts hunt", body_o, 0);
      quiet();
      frame(1'b0, 16, 9, 1'b0, 1'b1);

      // R8: broken sync pair in double density
      pulse_start(1'b1);
      for (int i = 0; i < 32; i++) send(8'h00);
      send(8'hFB);
      send(8'h12);
      send(8'hFB);
      send(8'hFB);
      send(8'h00);
      chk(body_o == 1'b0, "R8 second sync mismatch", body_o, 0);
      quiet();
      frame(1'b1, 32, 10, 1'b0, 1'b1);

      // R7: corrupted check byte
      pulse_start(1'b0);
      frame(1'b0, 16, 11, 1'b1, 1'b1);
      pulse_start(1'b0);
      chk(err_o == 0, "R11 err cleared by start", err_o, 0);

      // R9: sector hole mid-payload
      got = 0;
      for (int i = 0; i < 16; i++) send(8'h00);
      send(8'hFB);
      for (int i = 0; i < 100; i++) begin
         send(pat(12, i));
         expq.push_back(pat(12, i));
      end
      @(negedge clk);
      byte_vld_i = 1'b0;
      hole_i     = 1'b1;
      @(negedge clk);
      hole_i = 1'b0;
      chk(body_o == 1'b0, "R9 body dropped by hole", body_o, 0);
      for (int i = 100; i < 256; i++) send(pat(12, i));
      send(8'h00);
      quiet();
      @(negedge clk);
      chk(got == 100, "R9 payload stops at hole", got, 100);
      chk(done_o == 0 && ok_o == 0 && err_o == 0, "R9 no completion",
          {done_o, ok_o, err_o}, 0);

      // R11: start beats hole in the same cycle
      @(negedge clk);
      dbl_i   = 1'b0;
      start_i = 1'b1;
      hole_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      hole_i  = 1'b0;
      frame(1'b0, 16, 13, 1'b0, 1'b1);

      repeat (3) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule